// File: doc/BRIEF.md
# External Trigger Conditioner with Level Snapshot

This block sits in front of a data-acquisition engine. It takes a small group of asynchronous trigger pins and brings each one into the clock domain through a two-flop synchronizer. It then puts each pin in active-high form by inverting it when its polarity bit is set. A rising-edge detector on the conditioned copy of the pin chosen by the source select produces a one-cycle trigger pulse. This lets each pin fire on either its rising or its falling edge without a second detector.

The engine arms the block with a one-cycle start strobe. The block accepts only one trigger per arm. On the cycle of the accepted pulse, it latches the conditioned levels of every pin into a capture register, so the pin that caused the trigger always reads back as 1. A sticky flag shows that a fresh snapshot is waiting. A read strobe from software clears the flag.

Top module: `trig_condition`

## Requirements
- R1: A qualifying edge on a trigger pin, driven between clock edges, makes `trig_pulse` high after the third following rising clock edge: two synchronizer stages plus the registered pulse.
- R2: With `pol_invert[i]`=0, pin i fires on its rising edge. With `pol_invert[i]`=1, it fires on its falling edge. An edge in the other direction never fires.
- R3: Only the pin whose index equals `src_sel` can produce a pulse. Edges on other pins have no effect on `trig_pulse`.
- R4: `trig_pulse` is high for exactly one cycle per accepted trigger. A pin held at its active level does not retrigger.
- R5: A one-cycle `acq_arm` strobe arms the block. With no arm, edges produce no pulse, no capture and no flag.
- R6: Once a trigger is accepted, the block ignores further edges until `acq_arm` is strobed again.
- R7: On the cycle `trig_pulse` is high, `cap_levels[i]` equals synchronized `trig_pins[i]` XOR `pol_invert[i]` for every i. The bit at `src_sel` therefore reads 1.
- R8: `cap_levels` changes only on an accepted trigger. It holds through ignored edges and re-arming.
- R9: `cap_valid` goes to 1 with each accepted trigger and returns to 0 one cycle after a `cap_read` strobe. If a capture and a read fall in the same cycle, the capture wins.
- R10: While `rst` is high and right after it, `trig_pulse`, `cap_levels` and `cap_valid` are all 0 and the block is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_pins | input | N_TRIG | Asynchronous external trigger pins |
| pol_invert | input | N_TRIG | Per-pin inversion; 1 selects falling-edge triggering |
| src_sel | input | SEL_W | Index of the pin that may trigger |
| acq_arm | input | 1 | One-cycle strobe that arms the next acquisition |
| cap_read | input | 1 | Software read strobe that clears `cap_valid` |
| trig_pulse | output | 1 | One-cycle trigger to the acquisition engine |
| cap_levels | output | N_TRIG | Snapshot of conditioned pin levels at the accepted trigger |
| cap_valid | output | 1 | Sticky flag: a snapshot was taken since the last read |

## Verification
A stuck or wrong previous-value register in the edge detector shows at the ports within three cycles of a pin change. The symptom is a missing pulse, a pulse lasting two cycles, or a pulse on the wrong edge direction. A wrong arm state shows up as a pulse on the first edge after an unarmed reset, or as a second pulse after one accept. A snapshot loaded with the wrong inversion shows as a 0 in the selected bit on the same cycle as the pulse. A capture register that drifts shows as changed levels after an ignored edge, before the next arm.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int TRIG_N_DEF  = 4;
    localparam int SYNC_DEPTH  = 2;

    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_e;

    typedef struct packed {
        logic pulse;
        logic valid;
    } cap_flags_t;

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int N      = trig_pkg::TRIG_N_DEF,
    parameter int STAGES = trig_pkg::SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [N-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/trig_edge.sv
module trig_edge #(
    parameter int N  = trig_pkg::TRIG_N_DEF,
    parameter int SW = trig_pkg::sel_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  levels_sync,
    input  logic [N-1:0]  invert,
    input  logic [SW-1:0] sel,
    output logic [N-1:0]  active_hi,
    output logic          rise_sel
);
    logic [N-1:0] last_q;
    logic [N-1:0] rise_vec;

    for (genvar i = 0; i < N; i++) begin : g_cond
        assign active_hi[i] = levels_sync[i] ^ invert[i];
        assign rise_vec[i]  = active_hi[i] & ~last_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= '0;
        else     last_q <= active_hi;
    end

    always_comb begin
        rise_sel = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (SW'(i) == sel) rise_sel = rise_vec[i];
        end
    end
endmodule

// File: rtl/trig_capture.sv
module trig_capture
    import trig_pkg::*;
#(
    parameter int N = TRIG_N_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm,
    input  logic         rd_clr,
    input  logic         rise,
    input  logic [N-1:0] levels,
    output logic         pulse,
    output logic         valid,
    output logic [N-1:0] snap,
    output logic         armed
);
    arm_state_e state_q, state_d;
    cap_flags_t flags_q, flags_d;
    logic       accept;

    assign accept = (state_q == ST_ARMED) && rise;

    always_comb begin
        state_d = state_q;
        if (accept) state_d = ST_IDLE;
        if (arm)    state_d = ST_ARMED;

        flags_d.pulse = accept;
        flags_d.valid = flags_q.valid;
        if (rd_clr) flags_d.valid = 1'b0;
        if (accept) flags_d.valid = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            flags_q <= '0;
            snap    <= '0;
        end else begin
            state_q <= state_d;
            flags_q <= flags_d;
            if (accept) snap <= levels;
        end
    end

    assign pulse = flags_q.pulse;
    assign valid = flags_q.valid;
    assign armed = (state_q == ST_ARMED);
endmodule

// File: rtl/trig_condition.sv
module trig_condition
    import trig_pkg::*;
#(
    parameter int N_TRIG = TRIG_N_DEF,
    parameter int SEL_W  = sel_width(N_TRIG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TRIG-1:0] trig_pins,
    input  logic [N_TRIG-1:0] pol_invert,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic              acq_arm,
    input  logic              cap_read,
    output logic              trig_pulse,
    output logic [N_TRIG-1:0] cap_levels,
    output logic              cap_valid
);
    logic [N_TRIG-1:0] pins_sync;
    logic [N_TRIG-1:0] pins_active;
    logic              sel_rise;
    logic              armed;

    trig_sync #(.N(N_TRIG), .STAGES(SYNC_DEPTH)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (trig_pins),
        .sync_out (pins_sync)
    );

    trig_edge #(.N(N_TRIG), .SW(SEL_W)) i_edge (
        .clk         (clk),
        .rst         (rst),
        .levels_sync (pins_sync),
        .invert      (pol_invert),
        .sel         (src_sel),
        .active_hi   (pins_active),
        .rise_sel    (sel_rise)
    );

    trig_capture #(.N(N_TRIG)) i_cap (
        .clk    (clk),
        .rst    (rst),
        .arm    (acq_arm),
        .rd_clr (cap_read),
        .rise   (sel_rise),
        .levels (pins_active),
        .pulse  (trig_pulse),
        .valid  (cap_valid),
        .snap   (cap_levels),
        .armed  (armed)
    );
endmodule

// File: rtl/trig_condition_chk.sv
module trig_condition_chk #(
    parameter int N  = 4,
    parameter int SW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic [SW-1:0] src_sel,
    input logic          acq_arm,
    input logic          cap_read,
    input logic          trig_pulse,
    input logic [N-1:0]  cap_levels,
    input logic          cap_valid,
    input logic          armed
);
    p_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |=> !trig_pulse);

    p_needs_arm_r5: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> $past(armed));

    p_disarm_r6: assert property (@(posedge clk) disable iff (rst)
        (trig_pulse && !$past(acq_arm)) |-> !armed);

    p_sel_bit_r7: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> cap_levels[$past(src_sel)]);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !trig_pulse |-> $stable(cap_levels));

    p_set_r9: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> cap_valid);

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(cap_valid) |-> $past(cap_read));
endmodule

bind trig_condition trig_condition_chk #(.N(N_TRIG), .SW(SEL_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .src_sel    (src_sel),
    .acq_arm    (acq_arm),
    .cap_read   (cap_read),
    .trig_pulse (trig_pulse),
    .cap_levels (cap_levels),
    .cap_valid  (cap_valid),
    .armed      (armed)
);

// File: tb/test_trig_condition.sv
module test_trig_condition;
    localparam int N  = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  trig_pins = '0;
    logic [N-1:0]  pol_invert = '0;
    logic [SW-1:0] src_sel = '0;
    logic          acq_arm = 1'b0;
    logic          cap_read = 1'b0;
    logic          trig_pulse;
    logic [N-1:0]  cap_levels;
    logic          cap_valid;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    trig_condition #(.N_TRIG(N), .SEL_W(SW)) i_trig_condition (
        .clk(clk), .rst(rst), .trig_pins(trig_pins), .pol_invert(pol_invert),
        .src_sel(src_sel), .acq_arm(acq_arm), .cap_read(cap_read),
        .trig_pulse(trig_pulse), .cap_levels(cap_levels), .cap_valid(cap_valid)
    );

    // {pol[18:15], sel[14:13], before[12:9], after[8:5], pulse[4], cap[3:0]}
    localparam logic [18:0] VEC [9] = '{
        {4'b0000, 2'd0, 4'b0000, 4'b0001, 1'b1, 4'b0001},
        {4'b0001, 2'd0, 4'b0001, 4'b0000, 1'b1, 4'b0001},
        {4'b0000, 2'd0, 4'b0000, 4'b0010, 1'b0, 4'b0000},
        {4'b0000, 2'd2, 4'b0000, 4'b0100, 1'b1, 4'b0100},
        {4'b1010, 2'd3, 4'b1111, 4'b0111, 1'b1, 4'b1101},
        {4'b0000, 2'd1, 4'b0000, 4'b1101, 1'b0, 4'b0000},
        {4'b0100, 2'd2, 4'b0000, 4'b0000, 1'b0, 4'b0000},
        {4'b1111, 2'd1, 4'b1111, 4'b1101, 1'b1, 4'b0010},
        {4'b0001, 2'd0, 4'b0000, 4'b0001, 1'b0, 4'b0000}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [N-1:0] pol, input logic [SW-1:0] sel,
                            input logic [N-1:0] pins);
        @(negedge clk);
        rst = 1'b1; pol_invert = pol; src_sel = sel; trig_pins = pins;
        acq_arm = 1'b0; cap_read = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic arm_once();
        acq_arm = 1'b1;
        @(negedge clk);
        acq_arm = 1'b0;
    endtask

    // drive new pins at a negedge, watch six cycles; pulse expected only at k==3
    task automatic watch(input logic [N-1:0] pins, input bit exp_pulse, input bit rd_at2,
                         output bit ok, output logic [N-1:0] cap3, output logic val3);
        ok = 1'b1; cap3 = '0; val3 = 1'b0;
        trig_pins = pins;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (trig_pulse !== (exp_pulse && k == 3)) ok = 1'b0;
            if (k == 2 && rd_at2) cap_read = 1'b1;
            if (k == 3) begin
                cap_read = 1'b0; cap3 = cap_levels; val3 = cap_valid;
            end
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit ok;
        logic [N-1:0] cap3;
        logic val3;

        // R10: reset state
        do_reset('0, '0, '0);
        chk(trig_pulse === 1'b0 && cap_levels === '0 && cap_valid === 1'b0, "R10 reset",
            int'({trig_pulse, cap_levels, cap_valid}), 0);

        // table: R1 latency, R2 polarity, R3 select, R4 single cycle, R7 snapshot
        foreach (VEC[v]) begin
            do_reset(VEC[v][18:15], VEC[v][14:13], VEC[v][12:9]);
            arm_once();
            watch(VEC[v][8:5], VEC[v][4], 1'b0, ok, cap3, val3);
            chk(ok, $sformatf("R1/R2/R3/R4 vec%0d pulse", v), int'(ok), 1);
            chk(cap3 === VEC[v][3:0], $sformatf("R7/R8 vec%0d capture", v),
                int'(cap3), int'(VEC[v][3:0]));
        end

        // R5: no arm, edge ignored
        do_reset(4'b0000, 2'd0, 4'b0000);
        watch(4'b0001, 1'b0, 1'b0, ok, cap3, val3);
        chk(ok, "R5 unarmed pulse", int'(ok), 1);
        chk(cap_levels === '0 && cap_valid === 1'b0, "R5 unarmed capture/flag",
            int'({cap_levels, cap_valid}), 0);

        // armed trigger, then R6 ignored second edge, R8 hold
        trig_pins = 4'b0000;
        repeat (4) @(negedge clk);
        arm_once();
        watch(4'b0001, 1'b1, 1'b0, ok, cap3, val3);
        chk(ok && cap3 === 4'b0001, "R7 armed capture", int'(cap3), 1);
        chk(val3 === 1'b1, "R9 valid set", int'(val3), 1);
        trig_pins = 4'b0000;
        repeat (4) @(negedge clk);
        watch(4'b1011, 1'b0, 1'b0, ok, cap3, val3);
        chk(ok, "R6 second edge ignored", int'(ok), 1);
        chk(cap_levels === 4'b0001, "R8 capture held", int'(cap_levels), 1);

        // R9: read clears flag
        cap_read = 1'b1;
        @(negedge clk);
        cap_read = 1'b0;
        chk(cap_valid === 1'b0, "R9 read clears", int'(cap_valid), 0);

        // R8 re-arm does not change capture; R9 capture wins over same-cycle read
        trig_pins = 4'b0000;
        repeat (4) @(negedge clk);
        arm_once();
        chk(cap_levels === 4'b0001, "R8 held across arm", int'(cap_levels), 1);
        watch(4'b0111, 1'b1, 1'b1, ok, cap3, val3);
        chk(ok && cap3 === 4'b0111, "R7 re-armed capture", int'(cap3), 7);
        chk(val3 === 1'b1, "R9 set wins over read", int'(val3), 1);

        // R4: held active level does not retrigger after re-arm
        arm_once();
        repeat (6) @(negedge clk);
        chk(trig_pulse === 1'b0 && cap_levels === 4'b0111, "R4 level no retrigger",
            int'(cap_levels), 7);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule